// File: doc/BRIEF.md
# Single-Wire Slave Addressing Layer

This block decides, once per bus transaction, whether a slave on a single-wire multidrop bus is being addressed. It sits between the bit-level signalling engine, which turns bus waveforms into received bits, requests for transmit bits and reset notifications, and the memory command controller, which acts only while this layer reports the slave as selected. After every bus reset it collects one 8-bit addressing command, least significant bit first, and runs it against a 64-bit identity.

The identity holds an 8-bit family code in bits 7:0, a 48-bit serial number in bits 55:8 and an 8-bit check byte in bits 63:56. The check byte is worked out in hardware whenever the 56-bit value is loaded. The layer also owns the overdrive (high-speed) flag that the signalling engine uses to pick its timing.

The state machine has these states: IDLE (detached until the next bus reset), CMD (collecting the command byte), READ (sending identity bits), MATCH (comparing received bits), SRCH_TRUE, SRCH_CMP and SRCH_DIR (the three slots of one search step), and SELECTED. Its transitions are: bus reset goes from any state to CMD. From CMD, the 8th bit goes to READ, MATCH, SRCH_TRUE, SELECTED or IDLE, depending on the opcode. From READ, the 64th transmit request goes to SELECTED. From MATCH, a mismatch goes to IDLE and the 64th equal bit goes to SELECTED. SRCH_TRUE goes to SRCH_CMP, and SRCH_CMP goes to SRCH_DIR. From SRCH_DIR, a direction mismatch goes to IDLE, the 64th bit goes to SELECTED, and any other bit goes back to SRCH_TRUE.

Top module: `owrom_layer`

## Requirements
- R1: After power-on reset the layer is in IDLE with `selected_o`=0, `overdrive_o`=0 and `tx_bit_o`=1, and received bits are ignored until the first bus reset.
- R2: The check byte is the CRC of identity bits 55:0, taken least significant bit first. The generator is x^8+x^5+x^4+1, starting from zero. A pulse on `id_load_i` replaces bits 55:0 and recomputes the check byte.
- R3: Opcode 33h makes the layer send identity bits 0 to 63 in order on `tx_bit_o`, one per `tx_req_i`, and then select the slave.
- R4: Opcode 55h followed by 64 received bits equal to the identity selects the slave.
- R5: Under 55h, the first received bit that differs from the identity sends the layer to IDLE. The slave stays unselected and releases `tx_bit_o` to 1 for the rest of the transaction.
- R6: Opcode CCh selects the slave on the clock edge that takes in the 8th command bit.
- R7: Opcode F0h runs 64 search steps. Each step sends the identity bit, then its complement, then takes in a direction bit. After all 64 steps match, the slave is selected.
- R8: A search direction bit that differs from the identity bit sends the layer to IDLE, unselected, with `tx_bit_o`=1.
- R9: Opcode 3Ch selects the slave and sets `overdrive_o`.
- R10: Opcode 69h sets `overdrive_o` as soon as the opcode arrives, then matches like 55h. A mismatch clears `overdrive_o` unless it was already set before the opcode.
- R11: Any other opcode sends the layer to IDLE. A later CCh byte in the same transaction does not select, and `overdrive_o` is unchanged.
- R12: A bus reset clears `selected_o` and restarts command collection. It clears `overdrive_o` only when `bus_reset_long_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset and presence completed |
| bus_reset_long_i | input | 1 | Qualifies bus_reset_i as a regular-length reset |
| rx_valid_i | input | 1 | One-cycle pulse: a bit was written by the master |
| rx_bit_i | input | 1 | Value of the written bit |
| tx_req_i | input | 1 | One-cycle pulse: a read slot consumed tx_bit_o |
| tx_bit_o | output | 1 | Bit for the next read slot (1 = released) |
| id_load_i | input | 1 | Load strobe for the 56-bit identity body |
| id_value_i | input | 56 | Family code (7:0) and serial number (55:8) |
| selected_o | output | 1 | Slave addressed, memory commands allowed |
| overdrive_o | output | 1 | High-speed timing in force |

## Verification
The hardest case to reach from the ports is a drop-out at a late bit position, whether during a match or during a search. To get there, the master must send, or answer for, a long run of correct bits that depends on the computed check byte. The stimulus builds the full 64-bit identity, check byte included, arithmetically in the bench. It then sweeps the single wrong bit across all 64 positions for both commands, and sweeps all 256 opcodes after a reset. Overdrive retention is reached by ordering short and long resets around 69h with a wrong identity.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int CRC_W = 8;
    // generator x^8 + x^5 + x^4 + 1, without the x^8 term
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h31;

    localparam logic [7:0] OP_READ     = 8'h33;
    localparam logic [7:0] OP_MATCH    = 8'h55;
    localparam logic [7:0] OP_SKIP     = 8'hCC;
    localparam logic [7:0] OP_SEARCH   = 8'hF0;
    localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
    localparam logic [7:0] OP_OD_MATCH = 8'h69;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_CMP,
        ST_SRCH_DIR,
        ST_SELECTED
    } rom_state_e;

    function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    localparam logic [CRC_W-1:0] CRC_POLY_LSB = bit_reverse(CRC_POLY);

    // one LSB-first shift of the check register
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        logic [CRC_W-1:0] r;
        fb = c[0] ^ b;
        r  = c >> 1;
        if (fb) r = r ^ CRC_POLY_LSB;
        return r;
    endfunction

endpackage

// File: rtl/owrom_crc8.sv
module owrom_crc8
    import owrom_pkg::*;
#(
    parameter int DATA_W = 56
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    logic [CRC_W-1:0] stage [0:DATA_W];

    assign stage[0] = '0;

    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_stage
            assign stage[g+1] = crc_step(stage[g], data_i[g]);
        end
    endgenerate

    assign crc_o = stage[DATA_W];

endmodule

// File: rtl/owrom_id_store.sv
module owrom_id_store
    import owrom_pkg::*;
#(
    parameter int          DATA_W     = 56,
    parameter logic [55:0] DEFAULT_ID = 56'h00A53C960F170C,
    localparam int         ID_W       = DATA_W + CRC_W,
    localparam int         IDX_W      = $clog2(ID_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);

    function automatic logic [CRC_W-1:0] crc_over(input logic [DATA_W-1:0] v);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 0; i < DATA_W; i++) c = crc_step(c, v[i]);
        return c;
    endfunction

    localparam logic [DATA_W-1:0] BODY_RST = DEFAULT_ID[DATA_W-1:0];
    localparam logic [CRC_W-1:0]  CRC_RST  = crc_over(BODY_RST);

    logic [DATA_W-1:0] body_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_new;
    logic [ID_W-1:0]   full_id;

    owrom_crc8 #(.DATA_W(DATA_W)) crc_i (
        .data_i (value_i),
        .crc_o  (crc_new)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q <= BODY_RST;
            crc_q  <= CRC_RST;
        end else if (load_i) begin
            body_q <= value_i;
            crc_q  <= crc_new;
        end
    end

    assign full_id = {crc_q, body_q};
    assign bit_o   = full_id[idx_i];

    // R2: passing the whole identity, check byte included, through the generator leaves zero
    always_comb begin
        logic [CRC_W-1:0] res;
        res = '0;
        for (int i = 0; i < ID_W; i++) res = crc_step(res, full_id[i]);
        if (rst_n) begin
            a_r2_crc_residue: assert (res == '0)
                else $error("identity check byte inconsistent");
        end
    end

endmodule

// File: rtl/owrom_cmd_fsm.sv
module owrom_cmd_fsm
    import owrom_pkg::*;
#(
    parameter  int ID_W  = 64,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset_i,
    input  logic             bus_reset_long_i,
    input  logic             rx_valid_i,
    input  logic             rx_bit_i,
    input  logic             tx_req_i,
    input  logic             id_bit_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             tx_bit_o,
    output logic             selected_o,
    output logic             overdrive_o
);

    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(7);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);

    rom_state_e       state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic [6:0]       cmd_sr_q;
    logic [7:0]       cmd_byte;
    logic             cmd_done;
    logic             last_bit;
    logic             bit_miss;
    logic             od_q, od_prior_q, od_match_q, sel_q;

    assign cmd_byte = {rx_bit_i, cmd_sr_q};
    assign cmd_done = (state_q == ST_CMD) && rx_valid_i && (cnt_q == CMD_LAST);
    assign last_bit = (cnt_q == ID_LAST);
    assign bit_miss = (rx_bit_i != id_bit_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (bus_reset_i) begin
            state_d = ST_CMD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_CMD: begin
                    if (cmd_done) begin
                        unique case (cmd_byte)
                            OP_READ:                 state_d = ST_READ;
                            OP_MATCH, OP_OD_MATCH:   state_d = ST_MATCH;
                            OP_SEARCH:               state_d = ST_SRCH_TRUE;
                            OP_SKIP, OP_OD_SKIP:     state_d = ST_SELECTED;
                            default:                 state_d = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: begin
                    if (tx_req_i && last_bit) state_d = ST_SELECTED;
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        if (bit_miss)      state_d = ST_IDLE;
                        else if (last_bit) state_d = ST_SELECTED;
                    end
                end
                ST_SRCH_TRUE: begin
                    if (tx_req_i) state_d = ST_SRCH_CMP;
                end
                ST_SRCH_CMP: begin
                    if (tx_req_i) state_d = ST_SRCH_DIR;
                end
                ST_SRCH_DIR: begin
                    if (rx_valid_i) begin
                        if (bit_miss)      state_d = ST_IDLE;
                        else if (last_bit) state_d = ST_SELECTED;
                        else               state_d = ST_SRCH_TRUE;
                    end
                end
                ST_SELECTED: state_d = ST_SELECTED;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // counters, command shift register, select and speed flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cmd_sr_q   <= '0;
            sel_q      <= 1'b0;
            od_q       <= 1'b0;
            od_prior_q <= 1'b0;
            od_match_q <= 1'b0;
        end else if (bus_reset_i) begin
            cnt_q      <= '0;
            cmd_sr_q   <= '0;
            sel_q      <= 1'b0;
            od_match_q <= 1'b0;
            if (bus_reset_long_i) od_q <= 1'b0;
        end else begin
            sel_q <= (state_d == ST_SELECTED);
            unique case (state_q)
                ST_CMD: begin
                    if (rx_valid_i) begin
                        cmd_sr_q <= {rx_bit_i, cmd_sr_q[6:1]};
                        cnt_q    <= cmd_done ? '0 : cnt_q + 1'b1;
                    end
                    if (cmd_done) begin
                        od_match_q <= (cmd_byte == OP_OD_MATCH);
                        od_prior_q <= od_q;
                        if (cmd_byte == OP_OD_SKIP || cmd_byte == OP_OD_MATCH) od_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (tx_req_i) cnt_q <= cnt_q + 1'b1;
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (bit_miss && od_match_q && !od_prior_q) od_q <= 1'b0;
                    end
                end
                ST_SRCH_DIR: begin
                    if (rx_valid_i) cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_READ, ST_SRCH_TRUE: tx_bit_o = id_bit_i;
            ST_SRCH_CMP:           tx_bit_o = ~id_bit_i;
            default:               tx_bit_o = 1'b1;
        endcase
    end

    assign idx_o       = cnt_q;
    assign selected_o  = sel_q;
    assign overdrive_o = od_q;

    a_r12_reset_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> !selected_o);

    a_r12_long_reset_regular: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_i && bus_reset_long_i) |=> !overdrive_o);

    a_r12_short_reset_keeps_speed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_i && !bus_reset_long_i) |=> $stable(overdrive_o));

    a_r9_speed_rises_on_command: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdrive_o) |-> $past(state_q == ST_CMD));

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (tx_bit_o && !selected_o));

    a_r11_select_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> $past(state_q == ST_CMD || state_q == ST_READ ||
                                    state_q == ST_MATCH || state_q == ST_SRCH_DIR));

endmodule

// File: rtl/owrom_layer.sv
module owrom_layer
    import owrom_pkg::*;
#(
    parameter int                 FAMILY_W    = 8,
    parameter int                 SERIAL_W    = 48,
    parameter logic [FAMILY_W-1:0] FAMILY_CODE = 8'h0C,
    parameter logic [SERIAL_W-1:0] SERIAL_NUM  = 48'h00A5_3C96_0F17,
    localparam int                BODY_W      = FAMILY_W + SERIAL_W,
    localparam int                ID_W        = BODY_W + CRC_W,
    localparam int                IDX_W       = $clog2(ID_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset_i,
    input  logic              bus_reset_long_i,
    input  logic              rx_valid_i,
    input  logic              rx_bit_i,
    input  logic              tx_req_i,
    output logic              tx_bit_o,
    input  logic              id_load_i,
    input  logic [BODY_W-1:0] id_value_i,
    output logic              selected_o,
    output logic              overdrive_o
);

    logic [IDX_W-1:0] idx;
    logic             id_bit;

    owrom_id_store #(
        .DATA_W     (BODY_W),
        .DEFAULT_ID (56'({SERIAL_NUM, FAMILY_CODE}))
    ) id_store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (id_load_i),
        .value_i (id_value_i),
        .idx_i   (idx),
        .bit_o   (id_bit)
    );

    owrom_cmd_fsm #(.ID_W(ID_W)) fsm_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_reset_i      (bus_reset_i),
        .bus_reset_long_i (bus_reset_long_i),
        .rx_valid_i       (rx_valid_i),
        .rx_bit_i         (rx_bit_i),
        .tx_req_i         (tx_req_i),
        .id_bit_i         (id_bit),
        .idx_o            (idx),
        .tx_bit_o         (tx_bit_o),
        .selected_o       (selected_o),
        .overdrive_o      (overdrive_o)
    );

endmodule

// File: tb/owrom_layer_tb_top.sv
module owrom_layer_tb_top;

    localparam logic [7:0]  FAM = 8'h0C;
    localparam logic [47:0] SER = 48'h00A5_3C96_0F17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0, bus_long = 1'b0;
    logic rxv = 1'b0, rxb = 1'b0, txr = 1'b0;
    logic ld = 1'b0;
    logic [55:0] ldv = '0;
    logic tx_bit, sel, od;

    int vectors = 0;
    int miscompares = 0;
    logic [63:0] id_exp;

    always #10 clk = ~clk;

    owrom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_reset_i (bus_rst), .bus_reset_long_i (bus_long),
        .rx_valid_i (rxv), .rx_bit_i (rxb), .tx_req_i (txr),
        .tx_bit_o (tx_bit), .id_load_i (ld), .id_value_i (ldv),
        .selected_o (sel), .overdrive_o (od)
    );

    function automatic logic [63:0] make_id(input logic [55:0] body);
        logic [7:0] c;
        logic mix;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            mix = c[0] ^ body[i];
            c = {1'b0, c[7:1]};
            if (mix) c = c ^ 8'h8C;
        end
        return {c, body};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic long_rst);
        @(negedge clk); bus_rst = 1'b1; bus_long = long_rst;
        @(negedge clk); bus_rst = 1'b0; bus_long = 1'b0;
    endtask

    task automatic wbit(input logic b);
        @(negedge clk); rxv = 1'b1; rxb = b;
        @(negedge clk); rxv = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic rbit(output logic b);
        @(negedge clk); b = tx_bit; txr = 1'b1;
        @(negedge clk); txr = 1'b0;
    endtask

    task automatic load_id(input logic [55:0] v);
        @(negedge clk); ld = 1'b1; ldv = v;
        @(negedge clk); ld = 1'b0;
        id_exp = make_id(v);
    endtask

    task automatic read_rom(input string req);
        logic [63:0] got;
        logic b;
        do_reset(1'b1);
        wbyte(8'h33);
        for (int i = 0; i < 64; i++) begin rbit(b); got[i] = b; end
        check(req, got, id_exp);
        check("R3 selected after read", {63'd0, sel}, 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic b, bt, bc;
        logic [7:0] op;
        id_exp = make_id({SER, FAM});
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, bits ignored before first bus reset
        check("R1 selected at reset", {63'd0, sel}, 64'd0);
        check("R1 overdrive at reset", {63'd0, od}, 64'd0);
        check("R1 tx released at reset", {63'd0, tx_bit}, 64'd1);
        wbyte(8'hCC);
        check("R1 skip ignored before bus reset", {63'd0, sel}, 64'd0);

        // R3 / R2: read default identity, then loaded identities
        read_rom("R2 R3 default identity");
        load_id(56'h0000_0000_0000_01);
        read_rom("R2 R3 loaded identity a");
        load_id(56'hFF_FFFF_FFFF_FF_FF);
        read_rom("R2 R3 loaded identity b");
        load_id(56'h12_3456_789A_BC_28);
        read_rom("R2 R3 loaded identity c");

        // opcode sweep: R6 R9 R11
        for (int k = 0; k < 256; k++) begin
            op = 8'(k);
            do_reset(1'b1);
            wbyte(op);
            check($sformatf("R6 R9 R11 select op %02h", op), {63'd0, sel},
                  {63'd0, (op == 8'hCC || op == 8'h3C)});
            check($sformatf("R9 R10 R11 speed op %02h", op), {63'd0, od},
                  {63'd0, (op == 8'h3C || op == 8'h69)});
            if (op == 8'h33 || op == 8'hF0)
                check($sformatf("R3 R7 first tx op %02h", op), {63'd0, tx_bit}, {63'd0, id_exp[0]});
            else if (!(op inside {8'h55, 8'hCC, 8'h3C, 8'h69})) begin
                wbyte(8'hCC);
                check($sformatf("R11 later skip ignored op %02h", op), {63'd0, sel}, 64'd0);
            end
        end

        // R4 full match
        do_reset(1'b1);
        wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(id_exp[i]);
        check("R4 full match selects", {63'd0, sel}, 64'd1);

        // R5 mismatch at every position
        for (int p = 0; p < 64; p++) begin
            do_reset(1'b1);
            wbyte(8'h55);
            for (int i = 0; i < 64; i++) wbit((i == p) ? ~id_exp[i] : id_exp[i]);
            check($sformatf("R5 mismatch bit %0d select", p), {63'd0, sel}, 64'd0);
            check($sformatf("R5 mismatch bit %0d tx", p), {63'd0, tx_bit}, 64'd1);
        end

        // R7 full search
        do_reset(1'b1);
        wbyte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rbit(bt); rbit(bc);
            check($sformatf("R7 search true bit %0d", i), {63'd0, bt}, {63'd0, id_exp[i]});
            check($sformatf("R7 search comp bit %0d", i), {63'd0, bc}, {63'd0, ~id_exp[i]});
            wbit(id_exp[i]);
        end
        check("R7 search selects", {63'd0, sel}, 64'd1);

        // R8 direction mismatch at every position
        for (int p = 0; p < 64; p++) begin
            do_reset(1'b1);
            wbyte(8'hF0);
            for (int i = 0; i <= p; i++) begin
                rbit(bt); rbit(bc);
                wbit((i == p) ? ~id_exp[i] : id_exp[i]);
            end
            check($sformatf("R8 drop bit %0d select", p), {63'd0, sel}, 64'd0);
            rbit(b);
            check($sformatf("R8 drop bit %0d tx", p), {63'd0, b}, 64'd1);
        end

        // R10 overdrive match variants
        do_reset(1'b1);
        wbyte(8'h69);
        check("R10 speed after opcode", {63'd0, od}, 64'd1);
        for (int i = 0; i < 64; i++) wbit(id_exp[i]);
        check("R10 match selects", {63'd0, sel}, 64'd1);
        check("R10 match keeps speed", {63'd0, od}, 64'd1);
        do_reset(1'b0);
        check("R12 short reset deselects", {63'd0, sel}, 64'd0);
        check("R12 short reset keeps speed", {63'd0, od}, 64'd1);
        wbyte(8'h69);
        for (int i = 0; i < 64; i++) wbit(~id_exp[i]);
        check("R10 mismatch already fast keeps speed", {63'd0, od}, 64'd1);
        check("R10 mismatch no select", {63'd0, sel}, 64'd0);
        do_reset(1'b1);
        check("R12 long reset clears speed", {63'd0, od}, 64'd0);
        wbyte(8'h69);
        for (int i = 0; i < 64; i++) wbit((i == 40) ? ~id_exp[i] : id_exp[i]);
        check("R10 mismatch from regular clears speed", {63'd0, od}, 64'd0);

        // R11 unknown opcode keeps speed; R12 reset from selected
        do_reset(1'b1);
        wbyte(8'h3C);
        do_reset(1'b0);
        wbyte(8'hA5);
        check("R11 unknown opcode keeps speed", {63'd0, od}, 64'd1);
        check("R11 unknown opcode no select", {63'd0, sel}, 64'd0);
        wbyte(8'hCC);
        do_reset(1'b0);
        wbyte(8'hCC);
        check("R12 command restarts after reset", {63'd0, sel}, 64'd1);
        do_reset(1'b1);
        check("R12 reset clears select", {63'd0, sel}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule